// File: doc/BRIEF.md
# Serial Command and Register Port for a Multichannel Converter

This block is the serial control port of a multichannel data converter. A host frames each transaction by pulling an active-low select line low. It then toggles a serial clock, and the block captures one bit of a 16-bit word on every falling clock edge. The block runs in its own system clock domain. It synchronizes the select, clock and data lines and finds the falling edges there.

The word is decoded when its 16th bit arrives. A word with bit 15 clear and a non-zero value is a register access. A register write takes effect at once. A register read returns its byte on the serial output during the next eight clocks. Any other word is a mode command: standby, power-down, automatic scan, manual channel select, or a no-op. A mode command is held pending and takes effect only when select rises. In a command frame the serial output carries the current conversion result, which is sampled at the 16th edge.

A small bank of byte registers is provided. A read-only location returns the upper byte of the command that was last executed.

Top module: `spiCmdIf`

## Requirements
- R1: While `csN` is low, each falling edge of `sclk` shifts one bit of `sdi` into the word, MSB first. The bit count restarts every time `csN` falls, and the word is complete on the 16th falling edge.
- R2: A complete word with bit 15 = 0 and a value other than 0000h is a register access: address = bits 15:9, bit 8 = 1 for write and 0 for read, data = bits 7:0. Addresses 01h to NUM_REGS (01h to 08h by default) are implemented byte registers that reset to 00h, and a write to one of them takes effect at the 16th edge.
- R3: In a read frame, `sdo` carries the addressed byte MSB first, with data bit 7-j valid after falling edge 16+j for j = 0..7. `sdo` is low from edge 24 onward. A write frame keeps `sdo` low for the whole frame.
- R4: `sdo` is 0 while `csN` is high. From the fall of `csN` until the 16th falling edge, `sdo` is 0.
- R5: Command words set `modeOut` as follows: 8200h gives 1 (standby), 8300h gives 2 (power-down), A000h gives 3 (auto scan). A word of C000h + (ch << 10), with ch in 0..7 and bits 9:0 zero, gives 4 (manual) and sets `chanOut` = ch. Commands take effect when `csN` rises. After reset `modeOut` = 0 and `chanOut` = 0.
- R6: In a frame whose word is not a register access, `convData` is sampled at the 16th edge. Its bit RESULT_W-1-j is on `sdo` after falling edge 16+j, so with the default of 18 bits it occupies edges 16..33. `sdo` is 0 after edge 34.
- R7: A read of address 3Fh returns the upper byte of the command word that executed at the end of the last completed command frame. It returns 00h after reset. Writes to 3Fh are ignored.
- R8: A read of any other unimplemented address returns FFh. A write to such an address changes no register, even when its low address bits match an implemented register.
- R9: If `csN` rises before the 16th falling edge, the frame is discarded. Mode, channel, read-back byte and registers all stay unchanged.
- R10: The word 0000h, and any word with bit 15 = 1 that is not listed in R5, acts as a no-op. It leaves mode and channel unchanged and sets the read-back byte to 00h.
- R11: A register-access frame changes neither the mode, the channel nor the read-back byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host; bits move on its falling edge |
| sdi | input | 1 | Serial data in, MSB first |
| convData | input | RESULT_W | Current conversion result to send in command frames |
| sdo | output | 1 | Serial data out |
| modeOut | output | 3 | Operating mode: 0 idle, 1 standby, 2 power-down, 3 auto scan, 4 manual |
| chanOut | output | 3 | Channel chosen by the last manual command |

## Verification
The bench targets the edges of the output window: the read byte must start exactly after the 16th edge and fall silent after the 24th, and the conversion result must fill edges 16 to 33. A design that is off by one edge shifts every captured bit and fails the whole-stream compare. Frames cut short before the 16th edge are sent for both a command and a write. A design that decodes partial words would change mode or a register there. Writes to an address whose low bits alias an implemented register, and writes to the read-back location, catch decoders that truncate the address. Malformed command words catch a decoder that matches only the top bits, because such a design would switch mode instead of treating the word as a no-op.

// File: rtl/spiCmdPkg.sv
package spiCmdPkg;

  typedef enum logic [2:0] {
    MODE_IDLE      = 3'd0,
    MODE_STANDBY   = 3'd1,
    MODE_POWERDOWN = 3'd2,
    MODE_AUTO      = 3'd3,
    MODE_MANUAL    = 3'd4
  } modeE;

  // strobes from frame control to the datapath
  typedef struct packed {
    logic frameStart;  // select just fell
    logic frameEnd;    // select just rose
    logic shiftBit;    // falling serial clock edge inside a frame
    logic wordDone;    // this edge delivers bit 16 of the word
    logic sdiBit;      // data bit that goes with shiftBit
    logic csActive;    // select is currently low
  } spiStrobeT;

  localparam int WORD_BITS = 16;
  localparam int ADDR_W    = 7;
  localparam int BYTE_W    = 8;

  localparam logic [15:0] CMD_NOP     = 16'h0000;
  localparam logic [15:0] CMD_STANDBY = 16'h8200;
  localparam logic [15:0] CMD_PWRDN   = 16'h8300;
  localparam logic [15:0] CMD_AUTO    = 16'hA000;
  localparam logic [2:0]  MAN_PREFIX  = 3'b110;
  localparam logic [ADDR_W-1:0] RB_ADDR = 7'h3F;

endpackage

// File: rtl/spiFrameCtrl.sv
module spiFrameCtrl
  import spiCmdPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      sclk,
  input  logic      sdi,
  output spiStrobeT st
);

  localparam int CNT_W   = $clog2(WORD_BITS * 4);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_BITS - 1);

  logic [SYNC_STAGES-1:0] csPipe, sclkPipe, sdiPipe;
  logic csS, sclkS, sdiS;
  logic csPrev, sclkPrev;
  logic [CNT_W-1:0] bitCnt;
  logic fallEdge;

  generate
    if (SYNC_STAGES > 1) begin : gSyncMulti
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          csPipe   <= '1;
          sclkPipe <= '1;
          sdiPipe  <= '0;
        end else begin
          csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
          sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
          sdiPipe  <= {sdiPipe[SYNC_STAGES-2:0], sdi};
        end
      end
    end else begin : gSyncSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          csPipe   <= '1;
          sclkPipe <= '1;
          sdiPipe  <= '0;
        end else begin
          csPipe   <= csN;
          sclkPipe <= sclk;
          sdiPipe  <= sdi;
        end
      end
    end
  endgenerate

  assign csS   = csPipe[SYNC_STAGES-1];
  assign sclkS = sclkPipe[SYNC_STAGES-1];
  assign sdiS  = sdiPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b1;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  assign fallEdge = sclkPrev & ~sclkS & ~csS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (csPrev && !csS) begin
      bitCnt <= '0;
    end else if (fallEdge && bitCnt != CNT_MAX) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    st.frameStart = csPrev & ~csS;
    st.frameEnd   = ~csPrev & csS;
    st.shiftBit   = fallEdge;
    st.wordDone   = fallEdge && (bitCnt == CNT_LAST);
    st.sdiBit     = sdiS;
    st.csActive   = ~csS;
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    st.frameStart |=> (bitCnt == '0)); // R1
  AST_WORD_AT_16: assert property (@(posedge clk) disable iff (!rstN)
    st.wordDone |=> (bitCnt == CNT_W'(WORD_BITS))); // R1

endmodule

// File: rtl/spiRegBank.sv
module spiRegBank
  import spiCmdPkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [BYTE_W-1:0] cmdByte,
  output logic [BYTE_W-1:0] rdData
);

  localparam int BANK_W = NUM_REGS * BYTE_W;

  logic [BANK_W-1:0] regQ;
  logic hit;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g + 1);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          regQ[g*BYTE_W +: BYTE_W] <= '0;
        end else if (wrEn && addr == MY_ADDR) begin
          regQ[g*BYTE_W +: BYTE_W] <= wrData;
        end
      end
    end
  endgenerate

  always_comb begin
    hit    = 1'b0;
    rdData = '1;
    if (addr == RB_ADDR) rdData = cmdByte;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(i + 1)) begin
        hit    = 1'b1;
        rdData = regQ[i*BYTE_W +: BYTE_W];
      end
    end
  end

  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !hit) |=> $stable(regQ)); // R8

endmodule

// File: rtl/spiDataPath.sv
module spiDataPath
  import spiCmdPkg::*;
#(
  parameter int RESULT_W = 18,
  parameter int NUM_CH   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  spiStrobeT           st,
  input  logic [RESULT_W-1:0] convData,
  input  logic [BYTE_W-1:0]   rdData,
  output logic                regWrEn,
  output logic [ADDR_W-1:0]   regAddr,
  output logic [BYTE_W-1:0]   regWrData,
  output logic [BYTE_W-1:0]   cmdByte,
  output logic                sdo,
  output logic [2:0]          modeOut,
  output logic [2:0]          chanOut
);

  localparam int SHIFT_W = WORD_BITS - 1;

  logic [SHIFT_W-1:0]   inShift;
  logic [WORD_BITS-1:0] word;
  logic                 isAccess;
  logic [RESULT_W-1:0]  outShift;
  logic [RESULT_W-1:0]  readLoad;
  logic                 pendValid;
  logic [WORD_BITS-1:0] pendWord;
  logic                 cmdKnown;
  logic                 cmdManual;
  modeE                 cmdMode;
  modeE                 modeQ;
  logic [2:0]           chanQ;

  assign word      = {inShift, st.sdiBit};
  assign isAccess  = !word[WORD_BITS-1] && (word != CMD_NOP);
  assign regAddr   = word[WORD_BITS-1 -: ADDR_W];
  assign regWrData = word[BYTE_W-1:0];
  assign regWrEn   = st.wordDone && isAccess && word[BYTE_W];
  assign readLoad  = RESULT_W'(rdData) << (RESULT_W - BYTE_W);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift <= '0;
    end else if (st.frameStart) begin
      inShift <= '0;
    end else if (st.shiftBit) begin
      inShift <= word[SHIFT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
    end else if (st.frameStart) begin
      outShift <= '0;
    end else if (st.wordDone) begin
      if (isAccess) outShift <= word[BYTE_W] ? '0 : readLoad;
      else          outShift <= convData;
    end else if (st.shiftBit) begin
      outShift <= {outShift[RESULT_W-2:0], 1'b0};
    end
  end

  assign sdo = st.csActive & outShift[RESULT_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendWord  <= '0;
    end else if (st.frameStart || st.frameEnd) begin
      pendValid <= 1'b0;
    end else if (st.wordDone) begin
      pendValid <= !isAccess;
      pendWord  <= word;
    end
  end

  always_comb begin
    cmdKnown  = 1'b1;
    cmdManual = 1'b0;
    cmdMode   = modeQ;
    if (pendWord == CMD_STANDBY) begin
      cmdMode = MODE_STANDBY;
    end else if (pendWord == CMD_PWRDN) begin
      cmdMode = MODE_POWERDOWN;
    end else if (pendWord == CMD_AUTO) begin
      cmdMode = MODE_AUTO;
    end else if (pendWord[15:13] == MAN_PREFIX && pendWord[9:0] == '0
                 && int'(pendWord[12:10]) < NUM_CH) begin
      cmdMode   = MODE_MANUAL;
      cmdManual = 1'b1;
    end else begin
      cmdKnown = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= MODE_IDLE;
      chanQ   <= '0;
      cmdByte <= '0;
    end else if (st.frameEnd && pendValid) begin
      modeQ   <= cmdMode;
      cmdByte <= cmdKnown ? pendWord[15:8] : '0;
      if (cmdManual) chanQ <= pendWord[12:10];
    end
  end

  assign modeOut = modeQ;
  assign chanOut = chanQ;

  AST_SDO_QUIET_START: assert property (@(posedge clk) disable iff (!rstN)
    st.frameStart |=> !sdo); // R4
  AST_MODE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    !st.frameEnd |=> $stable(modeQ)); // R5
  AST_ABORT_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (st.frameEnd && !pendValid) |=> ($stable(cmdByte) && $stable(modeQ) && $stable(chanQ))); // R9
  AST_ACCESS_NO_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (st.wordDone && isAccess) |=> !pendValid); // R11

endmodule

// File: rtl/spiCmdIf.sv
module spiCmdIf
  import spiCmdPkg::*;
#(
  parameter int RESULT_W    = 18,
  parameter int NUM_REGS    = 8,
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sclk,
  input  logic                sdi,
  input  logic [RESULT_W-1:0] convData,
  output logic                sdo,
  output logic [2:0]          modeOut,
  output logic [2:0]          chanOut
);

  spiStrobeT           st;
  logic                regWrEn;
  logic [ADDR_W-1:0]   regAddr;
  logic [BYTE_W-1:0]   regWrData;
  logic [BYTE_W-1:0]   rdData;
  logic [BYTE_W-1:0]   cmdByte;

  spiFrameCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .csN  (csN),
    .sclk (sclk),
    .sdi  (sdi),
    .st   (st)
  );

  spiRegBank #(.NUM_REGS(NUM_REGS)) uRegs (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (regWrEn),
    .addr    (regAddr),
    .wrData  (regWrData),
    .cmdByte (cmdByte),
    .rdData  (rdData)
  );

  spiDataPath #(.RESULT_W(RESULT_W), .NUM_CH(NUM_CH)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .convData  (convData),
    .rdData    (rdData),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .cmdByte   (cmdByte),
    .sdo       (sdo),
    .modeOut   (modeOut),
    .chanOut   (chanOut)
  );

endmodule

// File: tb/tb_spiCmdIf.sv
module tb_spiCmdIf;

  localparam int HALF = 8;
  localparam int NVEC = 8;
  // {word, convData, expMode, expChan, expReadBack}
  localparam logic [47:0] VEC [NVEC] = '{
    {16'h8200, 18'h3A5C3, 3'd1, 3'd0, 8'h82},
    {16'hA000, 18'h2AAAA, 3'd3, 3'd0, 8'hA0},
    {16'hD400, 18'h15555, 3'd4, 3'd5, 8'hD4},
    {16'h0000, 18'h3FFFF, 3'd4, 3'd5, 8'h00},
    {16'h8300, 18'h00001, 3'd2, 3'd5, 8'h83},
    {16'hF123, 18'h20000, 3'd2, 3'd5, 8'h00},
    {16'hDC00, 18'h1F0F0, 3'd4, 3'd7, 8'hDC},
    {16'hC001, 18'h0C3C3, 3'd4, 3'd7, 8'h00}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b1;
  logic sdi = 1'b0;
  logic [17:0] convData = '0;
  logic sdo;
  logic [2:0] modeOut, chanOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [40:0] cap;

  always #5 clk = ~clk;

  spiCmdIf dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .convData(convData), .sdo(sdo), .modeOut(modeOut), .chanOut(chanOut)
  );

  task automatic checkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cap[0] = sdo after select falls, cap[k] = sdo after falling edge k
  task automatic runFrame(input logic [15:0] word, input int nEdges);
    cap = '0;
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    cap[0] = sdo;
    for (int k = 1; k <= nEdges; k++) begin
      sdi = (k <= 16) ? word[16-k] : 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      cap[k] = sdo;
      sclk = 1'b1;
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (3*HALF) @(negedge clk);
  endtask

  function automatic logic [40:0] expRead(input logic [7:0] d);
    logic [40:0] e = '0;
    for (int j = 0; j < 8; j++) e[16+j] = d[7-j];
    return e;
  endfunction

  function automatic logic [40:0] expConv(input logic [17:0] c);
    logic [40:0] e = '0;
    for (int j = 0; j < 18; j++) e[16+j] = c[17-j];
    return e;
  endfunction

  task automatic regRead(input logic [6:0] a, input int nEdges, input logic [7:0] exp, input string tag);
    runFrame({a, 1'b0, 8'h00}, nEdges);
    checkEq(tag, 64'(cap), 64'(expRead(exp)));
  endtask

  task automatic regWrite(input logic [6:0] a, input logic [7:0] d);
    runFrame({a, 1'b1, d}, 24);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    checkEq("R4 sdo idle after reset", 64'(sdo), 64'h0);
    checkEq("R5 reset mode", 64'(modeOut), 64'h0);
    checkEq("R5 reset channel", 64'(chanOut), 64'h0);
    regRead(7'h3F, 24, 8'h00, "R7 read-back after reset");
    regRead(7'h01, 24, 8'h00, "R2 register reset value");

    // register writes and reads
    regWrite(7'h01, 8'hA5);
    checkEq("R3 write frame keeps sdo low", 64'(cap), 64'h0);
    regRead(7'h01, 26, 8'hA5, "R3 R2 read byte window and tail");
    regWrite(7'h08, 8'h3C);
    regRead(7'h08, 24, 8'h3C, "R2 top implemented register");
    regRead(7'h09, 24, 8'hFF, "R8 first unimplemented address");
    regWrite(7'h21, 8'h77);
    regRead(7'h01, 24, 8'hA5, "R8 aliased write ignored");
    regRead(7'h21, 24, 8'hFF, "R8 unimplemented reads ones");
    regWrite(7'h3F, 8'h55);
    regRead(7'h3F, 24, 8'h00, "R7 write to read-back ignored");

    // command table
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] w;
      logic [17:0] c;
      {w, c} = VEC[v][47:14];
      convData = c;
      runFrame(w, 34);
      checkEq($sformatf("R6 R4 conversion stream vec%0d", v), 64'(cap), 64'(expConv(c)));
      checkEq($sformatf("R5 R10 mode vec%0d", v), 64'(modeOut), 64'(VEC[v][13:11]));
      checkEq($sformatf("R5 channel vec%0d", v), 64'(chanOut), 64'(VEC[v][10:8]));
      regRead(7'h3F, 24, VEC[v][7:0], $sformatf("R7 R10 read-back vec%0d", v));
    end
    checkEq("R4 sdo low with select high", 64'(sdo), 64'h0);

    // aborted frames
    convData = 18'h12345;
    runFrame(16'h8300, 34);
    checkEq("R5 power-down before abort", 64'(modeOut), 64'h2);
    runFrame(16'hA000, 10);
    checkEq("R9 aborted command mode", 64'(modeOut), 64'h2);
    regRead(7'h3F, 24, 8'h83, "R9 aborted command read-back");
    runFrame({7'h02, 1'b1, 8'h99}, 12);
    regRead(7'h02, 24, 8'h00, "R9 aborted write");

    // register access leaves mode alone
    regWrite(7'h03, 8'h11);
    checkEq("R11 mode after register write", 64'(modeOut), 64'h2);
    checkEq("R11 channel after register write", 64'(chanOut), 64'h7);
    regRead(7'h3F, 24, 8'h83, "R11 read-back after register write");
    regRead(7'h03, 24, 8'h11, "R1 R2 word capture");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule